// File: doc/BRIEF.md
# Serial HDLC Frame Receiver

This block takes a serial HDLC bit stream, one bit per strobe, and turns it into stored frame bytes. It locks onto the opening flag and strips the zero that the transmitter inserts after five ones. It collects bytes least significant bit first and runs the CRC-16 frame check over every byte, the two check bytes included. Received bytes are written into a byte FIFO. A processor can read only the bytes that the receiver has committed.

Bytes are committed in two ways. When a whole pool of bytes has built up inside one frame, the pool is committed and a pool interrupt pulses. When the frame ends with a closing flag or an abort, the rest is committed and an end-of-message interrupt pulses, with status bits for check result, abort and overflow. A frame shorter than the programmed minimum is removed without any notice. Bytes leave the FIFO when they are read. Their space is given back only when the processor issues the message-complete command. The message-delete command throws away everything not yet given back and ignores the rest of the current frame. A level-sensitive receiver reset and an enable bit control the whole receiver. Two status outputs report a line held at ones and a line carrying flags or frames.

Top module: `hdlc_rx`

## Requirements
- R1: After reset, fifo_avail is 0, both interrupts are low, and stat_idle and stat_line_active are 0.
- R2: A frame between flags is destuffed: a 0 that follows five 1s is removed. Its bytes, assembled least significant bit first, become readable on fifo_data in arrival order, and fifo_avail equals the byte count including the two check bytes.
- R3: A frame whose byte count, check bytes included, is below 3 + min_len_sel (00→3, 01→4, 10→5, 11→6) leaves fifo_avail unchanged and raises no irq_msg_end. A frame of exactly that length is accepted.
- R4: st_crc_ok is 1 after a frame end only if the CRC-16 (polynomial x^16+x^12+x^5+1, reflected, preset all ones) over all bytes gives residue 0xF0B8, the frame is byte aligned, and it was neither aborted nor overflowed. A bad check still stores the frame.
- R5: Seven consecutive 1s abort the frame. An aborted frame that meets the minimum length is committed with st_aborted=1 and st_crc_ok=0. A shorter aborted frame is dropped silently. stat_line_active goes to 0.
- R6: stat_idle is 1 once 15 or more consecutive 1s have been received, and returns to 0 on the next received 0.
- R7: stat_line_active becomes 1 when a flag (0, six 1s, 0) is received.
- R8: irq_pool_full pulses for one cycle each time 16 bytes of one frame are stored, and those bytes become readable before the frame ends.
- R9: Read bytes keep their FIFO space until cmd_msg_done is pulsed. Without it, a later frame can overflow the 32-byte FIFO.
- R10: A byte arriving at a full FIFO is discarded. The frame end then reports st_overflow=1, and the bytes stored before the FIFO filled stay readable.
- R11: A cmd_msg_drop pulse sets fifo_avail to 0 and ignores the current frame up to the next flag, so that frame raises no irq_msg_end.
- R12: With rx_en=0, strobed bits are ignored: no bytes are stored, no interrupt is raised, and line status stays 0.
- R13: While cmd_rx_reset is 1, all stored bytes are cleared and incoming frames are ignored. Reception resumes when it returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable mode bit |
| min_len_sel | input | 2 | Minimum frame length select, 3 + value bytes |
| rx_bit | input | 1 | Serial line data |
| rx_bit_vld | input | 1 | Strobe: rx_bit is valid this cycle |
| cmd_rx_reset | input | 1 | Level-sensitive receiver reset |
| cmd_msg_done | input | 1 | Pulse: give back space of bytes already read |
| cmd_msg_drop | input | 1 | Pulse: discard unreleased data and the current frame |
| fifo_pop | input | 1 | Read strobe, advances to the next byte |
| fifo_data | output | 8 | Oldest committed unread byte |
| fifo_avail | output | $clog2(DEPTH)+1 (6) | Number of committed unread bytes |
| irq_pool_full | output | 1 | One-cycle pulse: a pool of bytes was committed |
| irq_msg_end | output | 1 | One-cycle pulse: a frame ended and was committed |
| st_crc_ok | output | 1 | Last committed frame end: check good |
| st_aborted | output | 1 | Last committed frame end: aborted |
| st_overflow | output | 1 | Last committed frame end: bytes lost to full FIFO |
| stat_idle | output | 1 | 15 or more consecutive ones received |
| stat_line_active | output | 1 | Flags or frames are being received |

## Verification
A strobed bit is registered into a bit event at the first clock edge, and the byte store, commit, interrupts and end status follow at the second edge. stat_idle and stat_line_active follow at the first edge. The bench drives each bit for one cycle from the falling edge and then leaves the strobe low for one cycle. After a frame's last bit it waits four cycles before sampling avail, status and the interrupt counters. Interrupt pulses are counted by a monitor at rising edges, and all other outputs are sampled at falling edges. fifo_data is combinational from the read pointer, so each byte is checked before its pop and the next one is ready one edge later.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
    localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;
    localparam logic [15:0] CRC_POLY_R  = 16'h8408;

    // one decoded line event per strobed bit
    typedef struct packed {
        logic dat_vld;
        logic dat;
        logic flag;
        logic abrt;
    } bit_ev_t;

    typedef enum logic {ST_HUNT, ST_SYNC} asm_state_t;

    typedef struct packed {
        logic crc_ok;
        logic aborted;
        logic overflow;
    } end_stat_t;

    function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_R;
            else             r = r >> 1;
        end
        return r;
    endfunction

    function automatic logic [7:0] min_len(input logic [1:0] sel);
        return 8'd3 + {6'd0, sel};
    endfunction

endpackage

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
#(
    parameter int IDLE_ONES = 15
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    enable,
    input  logic    bit_in,
    input  logic    bit_vld,
    output bit_ev_t ev_o,
    output logic    idle_o,
    output logic    active_o
);
    localparam int OW = $clog2(IDLE_ONES + 1);

    logic [OW-1:0] ones_q;
    logic [OW-1:0] ones_nx;
    bit_ev_t       ev_q;
    logic          active_q;

    assign ones_nx = (ones_q == OW'(IDLE_ONES)) ? ones_q : ones_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            ones_q   <= '0;
            ev_q     <= '0;
            active_q <= 1'b0;
        end else begin
            ev_q <= '0;
            if (bit_vld) begin
                if (bit_in) begin
                    ones_q       <= ones_nx;
                    ev_q.dat     <= 1'b1;
                    ev_q.dat_vld <= (ones_nx <= OW'(5));
                    if (ones_nx == OW'(7)) begin
                        ev_q.abrt <= 1'b1;
                        active_q  <= 1'b0;
                    end
                end else begin
                    ones_q <= '0;
                    if (ones_q == OW'(6)) begin
                        ev_q.flag <= 1'b1;
                        active_q  <= 1'b1;
                    end else if (ones_q < OW'(5)) begin
                        ev_q.dat_vld <= 1'b1;
                        ev_q.dat     <= 1'b0;
                    end
                end
            end
        end
    end

    assign ev_o     = ev_q;
    assign idle_o   = (ones_q == OW'(IDLE_ONES));
    assign active_o = active_q;

endmodule

// File: rtl/hdlc_rx_assembler.sv
module hdlc_rx_assembler
    import hdlc_rx_pkg::*;
#(
    parameter int POOL = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       drop,
    input  logic [1:0] min_sel,
    input  bit_ev_t    ev_i,
    input  logic       fifo_full,
    output logic       push,
    output logic [7:0] push_data,
    output logic       commit,
    output logic       rollback,
    output logic       irq_pool,
    output logic       irq_end,
    output end_stat_t  stat_o
);
    localparam int UW = $clog2(POOL + 1);

    asm_state_t    state_q;
    logic [2:0]    bitcnt_q;
    logic [7:0]    sh_q;
    logic [7:0]    len_q;
    logic [UW-1:0] unc_q;
    logic [15:0]   crc_q;
    logic          ovf_q;
    logic          irq_pool_q, irq_end_q;
    end_stat_t     stat_q;

    logic       act, byte_done, pool_hit, end_evt, long_enough, end_ok;
    logic [7:0] new_byte;

    assign act         = enable && !drop;
    assign new_byte    = {ev_i.dat, sh_q[7:1]};
    assign byte_done   = act && (state_q == ST_SYNC) && ev_i.dat_vld && (bitcnt_q == 3'd7);
    assign push        = byte_done && !fifo_full;
    assign push_data   = new_byte;
    assign pool_hit    = push && (unc_q == UW'(POOL - 1));
    assign end_evt     = act && (state_q == ST_SYNC) && (len_q != 8'd0) && (ev_i.flag || ev_i.abrt);
    assign long_enough = (len_q >= min_len(min_sel));
    assign end_ok      = end_evt && long_enough;
    assign commit      = pool_hit || end_ok;
    assign rollback    = end_evt && !long_enough;

    always_ff @(posedge clk) begin
        if (rst || !act) begin
            state_q    <= ST_HUNT;
            bitcnt_q   <= '0;
            sh_q       <= '0;
            len_q      <= '0;
            unc_q      <= '0;
            crc_q      <= CRC_PRESET;
            ovf_q      <= 1'b0;
            irq_pool_q <= 1'b0;
            irq_end_q  <= 1'b0;
        end else begin
            irq_pool_q <= pool_hit;
            irq_end_q  <= end_ok;
            if (ev_i.flag) begin
                state_q  <= ST_SYNC;
                bitcnt_q <= '0;
                len_q    <= '0;
                unc_q    <= '0;
                crc_q    <= CRC_PRESET;
                ovf_q    <= 1'b0;
            end else if (ev_i.abrt) begin
                state_q <= ST_HUNT;
            end else if (ev_i.dat_vld && state_q == ST_SYNC) begin
                sh_q     <= new_byte;
                bitcnt_q <= bitcnt_q + 3'd1;
                if (byte_done) begin
                    crc_q <= crc16_byte(crc_q, new_byte);
                    if (len_q != 8'hFF) len_q <= len_q + 8'd1;
                    ovf_q <= ovf_q | fifo_full;
                    if (pool_hit)  unc_q <= '0;
                    else if (push) unc_q <= unc_q + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else if (end_ok) begin
            stat_q.crc_ok   <= (crc_q == CRC_RESIDUE) && (bitcnt_q == 3'd6) && !ev_i.abrt && !ovf_q;
            stat_q.aborted  <= ev_i.abrt;
            stat_q.overflow <= ovf_q;
        end
    end

    assign irq_pool = irq_pool_q;
    assign irq_end  = irq_end_q;
    assign stat_o   = stat_q;

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     drop_all,
    input  logic                     push,
    input  logic [W-1:0]             push_data,
    input  logic                     commit,
    input  logic                     rollback,
    input  logic                     pop,
    input  logic                     release_rd,
    output logic [W-1:0]             rd_data,
    output logic [$clog2(DEPTH):0]   avail,
    output logic                     full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wr_q, cm_q, rd_q, base_q;
    logic [AW:0]  rd_nx;

    assign avail   = cm_q - rd_q;
    assign full    = ((wr_q - base_q) == (AW+1)'(DEPTH));
    assign rd_nx   = rd_q + {{AW{1'b0}}, (pop && avail != '0)};
    assign rd_data = mem[rd_q[AW-1:0]];

    always_ff @(posedge clk) begin
        if (push) mem[wr_q[AW-1:0]] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_q   <= '0;
            cm_q   <= '0;
            rd_q   <= '0;
            base_q <= '0;
        end else if (drop_all) begin
            wr_q <= base_q;
            cm_q <= base_q;
            rd_q <= base_q;
        end else begin
            rd_q <= rd_nx;
            if (release_rd) base_q <= rd_nx;
            if (rollback) wr_q <= cm_q;
            else          wr_q <= wr_q + {{AW{1'b0}}, push};
            if (commit)   cm_q <= wr_q + {{AW{1'b0}}, push};
        end
    end

endmodule

// File: rtl/hdlc_rx.sv
module hdlc_rx
    import hdlc_rx_pkg::*;
#(
    parameter int DEPTH     = 32,
    parameter int POOL      = 16,
    parameter int IDLE_ONES = 15
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rx_en,
    input  logic [1:0]             min_len_sel,
    input  logic                   rx_bit,
    input  logic                   rx_bit_vld,
    input  logic                   cmd_rx_reset,
    input  logic                   cmd_msg_done,
    input  logic                   cmd_msg_drop,
    input  logic                   fifo_pop,
    output logic [7:0]             fifo_data,
    output logic [$clog2(DEPTH):0] fifo_avail,
    output logic                   irq_pool_full,
    output logic                   irq_msg_end,
    output logic                   st_crc_ok,
    output logic                   st_aborted,
    output logic                   st_overflow,
    output logic                   stat_idle,
    output logic                   stat_line_active
);
    logic       run;
    bit_ev_t    ev;
    logic       push, commit, rollback, full;
    logic [7:0] push_data;
    end_stat_t  stat;

    assign run = rx_en && !cmd_rx_reset;

    hdlc_rx_deframer #(.IDLE_ONES(IDLE_ONES)) u_deframer (
        .clk      (clk),
        .rst      (rst),
        .enable   (run),
        .bit_in   (rx_bit),
        .bit_vld  (rx_bit_vld),
        .ev_o     (ev),
        .idle_o   (stat_idle),
        .active_o (stat_line_active)
    );

    hdlc_rx_assembler #(.POOL(POOL)) u_assembler (
        .clk       (clk),
        .rst       (rst),
        .enable    (run),
        .drop      (cmd_msg_drop),
        .min_sel   (min_len_sel),
        .ev_i      (ev),
        .fifo_full (full),
        .push      (push),
        .push_data (push_data),
        .commit    (commit),
        .rollback  (rollback),
        .irq_pool  (irq_pool_full),
        .irq_end   (irq_msg_end),
        .stat_o    (stat)
    );

    hdlc_rx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .clear      (cmd_rx_reset),
        .drop_all   (cmd_msg_drop),
        .push       (push),
        .push_data  (push_data),
        .commit     (commit),
        .rollback   (rollback || !rx_en),
        .pop        (fifo_pop),
        .release_rd (cmd_msg_done),
        .rd_data    (fifo_data),
        .avail      (fifo_avail),
        .full       (full)
    );

    assign st_crc_ok   = stat.crc_ok;
    assign st_aborted  = stat.aborted;
    assign st_overflow = stat.overflow;

endmodule

// File: rtl/hdlc_rx_checker.sv
module hdlc_rx_checker #(
    parameter int DEPTH = 32,
    parameter int POOL  = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   rx_en,
    input logic                   rx_bit,
    input logic                   rx_bit_vld,
    input logic                   cmd_rx_reset,
    input logic                   cmd_msg_drop,
    input logic [$clog2(DEPTH):0] fifo_avail,
    input logic                   irq_pool_full,
    input logic                   irq_msg_end,
    input logic                   stat_idle,
    input logic                   stat_line_active
);
    localparam int AW = $clog2(DEPTH);

    // R1
    a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (fifo_avail == '0 && !irq_msg_end && !irq_pool_full && !stat_idle));

    // R6
    a_r6_idle_rises_on_one: assert property (@(posedge clk) disable iff (rst)
        (stat_idle && !$past(stat_idle)) |-> $past(rx_bit_vld && rx_bit));

    // R8
    a_r8_pool_pulse_single: assert property (@(posedge clk) disable iff (rst)
        irq_pool_full |=> !irq_pool_full);

    a_r8_pool_readable: assert property (@(posedge clk) disable iff (rst)
        irq_pool_full |-> (fifo_avail >= (AW+1)'(POOL)));

    // R10
    a_r10_avail_bounded: assert property (@(posedge clk) disable iff (rst)
        fifo_avail <= (AW+1)'(DEPTH));

    // R11
    a_r11_drop_empties: assert property (@(posedge clk) disable iff (rst)
        $past(cmd_msg_drop) |-> (fifo_avail == '0));

    // R12
    a_r12_disabled_silent: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && $past(!rx_en)) |-> (!irq_msg_end && !irq_pool_full && !stat_line_active));

    // R13
    a_r13_reset_clears: assert property (@(posedge clk) disable iff (rst)
        cmd_rx_reset |=> (fifo_avail == '0 && !irq_msg_end && !stat_line_active));

endmodule

bind hdlc_rx hdlc_rx_checker #(.DEPTH(DEPTH), .POOL(POOL)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .rx_en            (rx_en),
    .rx_bit           (rx_bit),
    .rx_bit_vld       (rx_bit_vld),
    .cmd_rx_reset     (cmd_rx_reset),
    .cmd_msg_drop     (cmd_msg_drop),
    .fifo_avail       (fifo_avail),
    .irq_pool_full    (irq_pool_full),
    .irq_msg_end      (irq_msg_end),
    .stat_idle        (stat_idle),
    .stat_line_active (stat_line_active)
);

// File: tb/tb_hdlc_rx.sv
module tb_hdlc_rx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_en = 1'b1;
    logic [1:0] min_len_sel = 2'd0;
    logic       rx_bit = 1'b1;
    logic       rx_bit_vld = 1'b0;
    logic       cmd_rx_reset = 1'b0;
    logic       cmd_msg_done = 1'b0;
    logic       cmd_msg_drop = 1'b0;
    logic       fifo_pop = 1'b0;
    logic [7:0] fifo_data;
    logic [5:0] fifo_avail;
    logic       irq_pool_full, irq_msg_end;
    logic       st_crc_ok, st_aborted, st_overflow;
    logic       stat_idle, stat_line_active;

    int n_chk = 0;
    int n_err = 0;
    int n_end = 0;
    int n_pool = 0;
    int sone = 0;
    int flen = 0;
    logic [7:0] fbuf [64];
    bit done = 0;

    always #5 clk = ~clk;

    hdlc_rx dut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .min_len_sel(min_len_sel),
        .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld), .cmd_rx_reset(cmd_rx_reset),
        .cmd_msg_done(cmd_msg_done), .cmd_msg_drop(cmd_msg_drop), .fifo_pop(fifo_pop),
        .fifo_data(fifo_data), .fifo_avail(fifo_avail), .irq_pool_full(irq_pool_full),
        .irq_msg_end(irq_msg_end), .st_crc_ok(st_crc_ok), .st_aborted(st_aborted),
        .st_overflow(st_overflow), .stat_idle(stat_idle), .stat_line_active(stat_line_active)
    );

    always @(posedge clk) begin
        if (irq_msg_end)   n_end  <= n_end + 1;
        if (irq_pool_full) n_pool <= n_pool + 1;
    end

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            logic fb = r[0] ^ d[i];
            r = {1'b0, r[15:1]};
            if (fb) r = r ^ 16'h8408;
        end
        return r;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_raw(input logic b);
        @(negedge clk);
        rx_bit = b;
        rx_bit_vld = 1'b1;
        @(negedge clk);
        rx_bit_vld = 1'b0;
    endtask

    task automatic send_flag();
        send_raw(1'b0);
        for (int i = 0; i < 6; i++) send_raw(1'b1);
        send_raw(1'b0);
        sone = 0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            send_raw(v[i]);
            if (v[i]) begin
                sone++;
                if (sone == 5) begin
                    send_raw(1'b0);
                    sone = 0;
                end
            end else begin
                sone = 0;
            end
        end
    endtask

    task automatic build(input int ndata, input bit bad);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < ndata; i++) begin
            fbuf[i] = 8'($urandom);
            c = ref_crc(c, fbuf[i]);
        end
        c = ~c;
        fbuf[ndata]   = c[7:0] ^ {7'd0, bad};
        fbuf[ndata+1] = c[15:8];
        flen = ndata + 2;
    endtask

    task automatic send_frame();
        send_flag();
        for (int i = 0; i < flen; i++) send_byte(fbuf[i]);
        send_flag();
        wait_cyc(4);
    endtask

    task automatic read_bytes(input string tag, input int cnt);
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk);
            chk(tag, int'(fifo_data), int'(fbuf[i]));
            fifo_pop = 1'b1;
            @(negedge clk);
            fifo_pop = 1'b0;
        end
    endtask

    task automatic release_space();
        @(negedge clk);
        cmd_msg_done = 1'b1;
        @(negedge clk);
        cmd_msg_done = 1'b0;
    endtask

    task automatic good_frame(input string tag, input int ndata, input bit bad);
        int e0;
        build(ndata, bad);
        e0 = n_end;
        send_frame();
        chk({tag, " end"}, n_end - e0, 1);
        chk({tag, " avail"}, int'(fifo_avail), flen);
        chk({tag, " crc_ok"}, int'(st_crc_ok), bad ? 0 : 1);
        chk({tag, " aborted"}, int'(st_aborted), 0);
        chk({tag, " overflow"}, int'(st_overflow), 0);
        read_bytes({tag, " data"}, flen);
        release_space();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        int e0, p0, seed;
        seed = $urandom(32'd20517);
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);

        // R1 reset state
        chk("R1 avail", int'(fifo_avail), 0);
        chk("R1 irq_end", n_end, 0);
        chk("R1 idle", int'(stat_idle), 0);
        chk("R1 active", int'(stat_line_active), 0);

        // R7 flag raises line activity
        send_flag();
        wait_cyc(2);
        chk("R7 active", int'(stat_line_active), 1);

        // R2 random frames, plus stuffing-heavy directed frame
        for (int k = 0; k < 6; k++) good_frame("R2 random", int'($urandom_range(14, 2)), 1'b0);
        build(4, 1'b0);
        fbuf[0] = 8'hFF; fbuf[1] = 8'h7E; fbuf[2] = 8'hFE; fbuf[3] = 8'h3F;
        begin
            logic [15:0] c = 16'hFFFF;
            for (int i = 0; i < 4; i++) c = ref_crc(c, fbuf[i]);
            c = ~c;
            fbuf[4] = c[7:0];
            fbuf[5] = c[15:8];
        end
        e0 = n_end;
        send_frame();
        chk("R2 stuffed end", n_end - e0, 1);
        chk("R2 stuffed crc", int'(st_crc_ok), 1);
        chk("R2 stuffed avail", int'(fifo_avail), 6);
        read_bytes("R2 stuffed data", 6);
        release_space();

        // R4 bad check sequence
        good_frame("R4 bad fcs", 7, 1'b1);

        // R3 minimum length per select value
        for (int s = 0; s < 4; s++) begin
            min_len_sel = 2'(s);
            build(s, 1'b0);
            e0 = n_end;
            send_frame();
            chk("R3 short end", n_end - e0, 0);
            chk("R3 short avail", int'(fifo_avail), 0);
            good_frame("R3 exact min", s + 1, 1'b0);
        end
        min_len_sel = 2'd0;

        // R8 pool interrupt mid frame
        build(18, 1'b0);
        p0 = n_pool;
        e0 = n_end;
        send_flag();
        for (int i = 0; i < 16; i++) send_byte(fbuf[i]);
        wait_cyc(4);
        chk("R8 pool count", n_pool - p0, 1);
        chk("R8 pool avail", int'(fifo_avail), 16);
        chk("R8 no end yet", n_end - e0, 0);
        for (int i = 16; i < flen; i++) send_byte(fbuf[i]);
        send_flag();
        wait_cyc(4);
        chk("R8 end", n_end - e0, 1);
        chk("R8 avail", int'(fifo_avail), 20);
        chk("R8 crc", int'(st_crc_ok), 1);
        read_bytes("R8 data", 20);
        release_space();

        // R5 abort of a long frame
        build(6, 1'b0);
        e0 = n_end;
        send_flag();
        for (int i = 0; i < 8; i++) send_byte(fbuf[i]);
        for (int i = 0; i < 7; i++) send_raw(1'b1);
        wait_cyc(4);
        chk("R5 end", n_end - e0, 1);
        chk("R5 aborted", int'(st_aborted), 1);
        chk("R5 crc", int'(st_crc_ok), 0);
        chk("R5 active", int'(stat_line_active), 0);
        chk("R5 avail", int'(fifo_avail), 8);
        read_bytes("R5 data", 8);
        release_space();
        // R5 abort of a short frame
        e0 = n_end;
        send_flag();
        send_byte(8'h5A);
        for (int i = 0; i < 7; i++) send_raw(1'b1);
        wait_cyc(4);
        chk("R5 short end", n_end - e0, 0);
        chk("R5 short avail", int'(fifo_avail), 0);

        // R6 idle threshold
        send_raw(1'b0);
        for (int i = 0; i < 14; i++) send_raw(1'b1);
        wait_cyc(2);
        chk("R6 idle at 14", int'(stat_idle), 0);
        send_raw(1'b1);
        wait_cyc(2);
        chk("R6 idle at 15", int'(stat_idle), 1);
        for (int i = 0; i < 5; i++) send_raw(1'b1);
        wait_cyc(2);
        chk("R6 idle held", int'(stat_idle), 1);
        send_raw(1'b0);
        wait_cyc(2);
        chk("R6 idle cleared", int'(stat_idle), 0);

        // R9 / R10 space kept until release, overflow status
        build(18, 1'b0);
        send_frame();
        read_bytes("R9 first data", 20);
        build(18, 1'b0);
        e0 = n_end;
        send_frame();
        chk("R10 end", n_end - e0, 1);
        chk("R10 overflow", int'(st_overflow), 1);
        chk("R10 crc", int'(st_crc_ok), 0);
        chk("R9 unreleased space", int'(fifo_avail), 12);
        read_bytes("R10 kept data", 12);
        release_space();
        good_frame("R9 after release", 18, 1'b0);

        // R11 drop command
        build(5, 1'b0);
        send_frame();
        chk("R11 prior avail", int'(fifo_avail), 7);
        build(8, 1'b0);
        e0 = n_end;
        send_flag();
        for (int i = 0; i < 5; i++) send_byte(fbuf[i]);
        @(negedge clk);
        cmd_msg_drop = 1'b1;
        @(negedge clk);
        cmd_msg_drop = 1'b0;
        for (int i = 5; i < flen; i++) send_byte(fbuf[i]);
        send_flag();
        wait_cyc(4);
        chk("R11 avail", int'(fifo_avail), 0);
        chk("R11 end", n_end - e0, 0);
        good_frame("R11 next frame", 6, 1'b0);

        // R12 receiver disabled
        rx_en = 1'b0;
        build(6, 1'b0);
        e0 = n_end;
        send_frame();
        chk("R12 avail", int'(fifo_avail), 0);
        chk("R12 end", n_end - e0, 0);
        chk("R12 active", int'(stat_line_active), 0);
        rx_en = 1'b1;
        good_frame("R12 re-enabled", 6, 1'b0);

        // R13 level receiver reset
        build(5, 1'b0);
        send_frame();
        chk("R13 prior avail", int'(fifo_avail), 7);
        @(negedge clk);
        cmd_rx_reset = 1'b1;
        build(6, 1'b0);
        e0 = n_end;
        send_frame();
        chk("R13 avail", int'(fifo_avail), 0);
        chk("R13 end", n_end - e0, 0);
        @(negedge clk);
        cmd_rx_reset = 1'b0;
        good_frame("R13 resumed", 9, 1'b0);

        done = 1;
        finish_run();
    end

endmodule